// File: doc/BRIEF.md
# Serial-Bus Reset Sequencer (short and long reset)

This block decides when a physical-layer node drives the reset condition onto a serial bus, and for how long. It offers two kinds of reset. The long kind is driven at once, without asking for the bus, and lasts long enough for any transaction still in flight to finish. The short kind is driven only after this node has won bus arbitration, so it can be much briefer. An active-low mode strap enables the short kind. With the strap high the node runs in legacy mode: it never arbitrates for a reset, and it stretches every arbitrated reset it receives from another node into a long one.

Software starts a reset by writing the control register at address 9. Bit 7 asks for a short reset and bit 6 asks for a long one. Bit 7 reads back as a pending flag and clears itself once the reset starts. The port logic reports a reset it has detected with a one-cycle indication, plus a flag that says whether that reset was arbitrated. The block propagates such a reset by driving reset itself for the matching duration.

When a reset ends, the block raises a one-cycle completion pulse together with the type of the reset that just ended. Both durations are counted in clock cycles and are derived from a clock-frequency parameter.

Top module: `busrst_ctl`

## Requirements
- R1: After a synchronous reset, `drive_rst`, `arb_req`, `rst_is_short`, `done` and `done_short` are 0 and `ctl_rdata` is 0.
- R2: A write to address 9 with bit 6 set starts a long reset without arbitration. `drive_rst` rises in the cycle after the write and stays high for exactly LONG_CYC = CLK_MHZ*LONG_NS/1000 cycles.
- R3: In short mode (`short_en_n` = 0), a write to address 9 with bit 7 set makes `ctl_rdata` bit 7 read 1. `arb_req` rises one cycle later. A grant sampled while `arb_req` is high starts a short reset of exactly SHORT_CYC = ceil(CLK_MHZ*SHORT_NS/1000) cycles, and from then on bit 7 reads 0.
- R4: In legacy mode (`short_en_n` = 1), a write of bit 7 has no effect: bit 7 reads 0, `arb_req` stays low and no reset is driven.
- R5: A detected non-arbitrated reset (`rx_reset` with `rx_arb` = 0) starts a long reset in the next cycle in either mode. A detected arbitrated reset starts a short reset in short mode and a long reset in legacy mode, without this node arbitrating.
- R6: A long trigger (a bit-6 write or a long-class detected reset) that arrives while a short request is arbitrating, or while any reset is being driven, takes priority. `arb_req` drops, the type becomes long, and `drive_rst` then stays high for exactly LONG_CYC cycles counted from that trigger.
- R7: `done` is high for exactly one cycle, in the first cycle after `drive_rst` falls. `done_short` in that cycle is 1 for a short reset and 0 for a long one.
- R8: While `drive_rst` is high, `rst_is_short` is 1 for a short reset and 0 for a long reset.
- R9: A bit-7 write while a reset is being driven, and any write to an address other than 9, is ignored: bit 7 reads 0 and no arbitration follows.
- R10: If the strap goes high while a short request is pending or arbitrating, the request is dropped: `arb_req` falls and bit 7 reads 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| short_en_n | input | 1 | Mode strap; low enables short resets, high selects legacy mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register write address |
| reg_wdata | input | DW | Register write data (bit 7 short request, bit 6 long request at address 9) |
| ctl_rdata | output | DW | Readback of the control register; bit 7 is the pending short request |
| arb_grant | input | 1 | Arbitration won |
| arb_req | output | 1 | Arbitration request for a short reset |
| rx_reset | input | 1 | One-cycle indication that a port detected a bus reset |
| rx_arb | input | 1 | Detected reset was arbitrated (valid with rx_reset) |
| drive_rst | output | 1 | Drive the reset condition onto the bus |
| rst_is_short | output | 1 | Type of the reset being driven (1 short) |
| done | output | 1 | One-cycle pulse when a reset ends |
| done_short | output | 1 | Type of the reset that just ended, valid with done |

## Verification
A wrong state in the sequencer shows up at the ports mostly as a wrong duration. A counter loaded with the wrong length, or not reloaded on a long preemption, changes the number of cycles `drive_rst` stays high, and this is visible as soon as the reset ends. A wrong mode decision flips `rst_is_short` in the first driven cycle. A pending flag that is set or cleared wrongly shows on `ctl_rdata` bit 7 one cycle after the write, and on `arb_req` one cycle after that. The bench measures every reset length to the cycle and checks the completion pulse in the exact cycle after the reset ends.

// File: rtl/busrst_pkg.sv
package busrst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARB   = 2'd1,
    ST_DRIVE = 2'd2
  } brs_state_t;

  // control register location and the bit positions software writes
  localparam logic [3:0] CTL_ADDR  = 4'd9;
  localparam int         SHORT_BIT = 7;
  localparam int         LONG_BIT  = 6;

endpackage

// File: rtl/busrst_decode.sv
module busrst_decode
  import busrst_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          short_mode,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          rx_reset,
  input  logic          rx_arb,
  output logic          long_trig,
  output logic          short_wr,
  output logic          rx_short
);

  logic          hit;
  logic [DW-1:0] wdata_unused;

  assign wdata_unused = reg_wdata;
  assign hit          = reg_wr && (reg_addr == AW'(CTL_ADDR));

  // a received reset is long unless it was arbitrated and this node honours short ones
  assign long_trig = (hit && reg_wdata[LONG_BIT]) ||
                     (rx_reset && (!rx_arb || !short_mode));
  assign rx_short  = rx_reset && rx_arb && short_mode;
  assign short_wr  = hit && reg_wdata[SHORT_BIT] && short_mode;

endmodule

// File: rtl/busrst_timer.sv
module busrst_timer #(
  parameter int LONG_CYC  = 16700,
  parameter int SHORT_CYC = 130,
  parameter int CW        = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_long,
  output logic expire
);

  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_long ? LONG_LD : SHORT_LD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LONG_LD); // R2

  AST_CNT_DESCENDS: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6

endmodule

// File: rtl/busrst_ctl.sv
module busrst_ctl
  import busrst_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int LONG_NS  = 167000,
  parameter int SHORT_NS = 1300,
  parameter int AW       = 4,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          short_en_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] ctl_rdata,
  input  logic          arb_grant,
  output logic          arb_req,
  input  logic          rx_reset,
  input  logic          rx_arb,
  output logic          drive_rst,
  output logic          rst_is_short,
  output logic          done,
  output logic          done_short
);

  localparam int LONG_CYC  = CLK_MHZ * LONG_NS / 1000;
  localparam int SHORT_CYC = (CLK_MHZ * SHORT_NS + 999) / 1000;
  localparam int CW        = $clog2(LONG_CYC + 1);

  logic       short_mode;
  logic       long_trig, short_wr, rx_short;
  logic       load, load_long, expire;
  brs_state_t st, st_n;
  logic       pend_q, pend_n;
  logic       type_q, type_n;
  logic       drive_q, arb_q, short_q, done_q, done_short_q;
  logic       done_n;

  assign short_mode = ~short_en_n;

  busrst_decode #(.AW(AW), .DW(DW)) u_decode (
    .short_mode (short_mode),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .rx_reset   (rx_reset),
    .rx_arb     (rx_arb),
    .long_trig  (long_trig),
    .short_wr   (short_wr),
    .rx_short   (rx_short)
  );

  busrst_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC), .CW(CW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_long (load_long),
    .expire    (expire)
  );

  always_comb begin
    st_n      = st;
    load      = 1'b0;
    load_long = 1'b0;
    type_n    = type_q;
    done_n    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (long_trig) begin
          st_n = ST_DRIVE; load = 1'b1; load_long = 1'b1; type_n = 1'b0;
        end else if (rx_short) begin
          st_n = ST_DRIVE; load = 1'b1; type_n = 1'b1;
        end else if (pend_q && short_mode) begin
          st_n = ST_ARB;
        end
      end
      ST_ARB: begin
        if (long_trig) begin
          st_n = ST_DRIVE; load = 1'b1; load_long = 1'b1; type_n = 1'b0;
        end else if (rx_short) begin
          st_n = ST_DRIVE; load = 1'b1; type_n = 1'b1;
        end else if (!short_mode) begin
          st_n = ST_IDLE;
        end else if (arb_grant) begin
          st_n = ST_DRIVE; load = 1'b1; type_n = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (long_trig) begin
          load = 1'b1; load_long = 1'b1; type_n = 1'b0;
        end else if (expire) begin
          st_n = ST_IDLE; done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // pending short request: set by a write outside a drive, cleared once a reset starts
  always_comb begin
    pend_n = pend_q;
    if (load || !short_mode)               pend_n = 1'b0;
    else if (short_wr && st != ST_DRIVE)   pend_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      pend_q       <= 1'b0;
      type_q       <= 1'b0;
      drive_q      <= 1'b0;
      arb_q        <= 1'b0;
      short_q      <= 1'b0;
      done_q       <= 1'b0;
      done_short_q <= 1'b0;
    end else begin
      st           <= st_n;
      pend_q       <= pend_n;
      type_q       <= type_n;
      drive_q      <= (st_n == ST_DRIVE);
      arb_q        <= (st_n == ST_ARB);
      short_q      <= (st_n == ST_DRIVE) && type_n;
      done_q       <= done_n;
      done_short_q <= done_n && type_q;
    end
  end

  assign ctl_rdata    = {{(DW-1){1'b0}}, pend_q} << SHORT_BIT;
  assign arb_req      = arb_q;
  assign drive_rst    = drive_q;
  assign rst_is_short = short_q;
  assign done         = done_q;
  assign done_short   = done_short_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7

  AST_DONE_AFTER_DRIVE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!drive_q && $past(drive_q))); // R7

  AST_LEGACY_NO_ARB: assert property (@(posedge clk) disable iff (rst)
    $past(!short_mode) |-> !arb_q); // R4

  AST_PEND_GONE_AT_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_q) |-> !pend_q); // R3

  AST_SHORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($rose(drive_q) && short_q) |-> ($past(arb_grant && arb_q) || $past(rx_short))); // R5

  AST_LONG_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(long_trig) |-> (drive_q && !short_q && !arb_q)); // R6

endmodule

// File: tb/tb_busrst_ctl.sv
module tb_busrst_ctl;

  localparam int CLK_MHZ   = 10;
  localparam int LONG_NS   = 167000;
  localparam int SHORT_NS  = 1300;
  localparam int LONG_LEN  = CLK_MHZ * LONG_NS / 1000;
  localparam int SHORT_LEN = (CLK_MHZ * SHORT_NS + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       short_en_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       arb_grant = 1'b0;
  logic       arb_req;
  logic       rx_reset = 1'b0;
  logic       rx_arb = 1'b0;
  logic       drive_rst, rst_is_short, done, done_short;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  busrst_ctl #(.CLK_MHZ(CLK_MHZ), .LONG_NS(LONG_NS), .SHORT_NS(SHORT_NS)) dut (
    .clk(clk), .rst(rst), .short_en_n(short_en_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ctl_rdata(ctl_rdata),
    .arb_grant(arb_grant), .arb_req(arb_req), .rx_reset(rx_reset), .rx_arb(rx_arb),
    .drive_rst(drive_rst), .rst_is_short(rst_is_short), .done(done), .done_short(done_short)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 long write, 1 short write, 2 received plain reset, 3 received arbitrated reset
  function automatic int exp_len(bit smode, int kind);
    case (kind)
      1:       return smode ? SHORT_LEN : 0;
      3:       return smode ? SHORT_LEN : LONG_LEN;
      default: return LONG_LEN;
    endcase
  endfunction

  function automatic bit exp_short(bit smode, int kind);
    return smode && (kind == 1 || kind == 3);
  endfunction

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rx(bit arb);
    @(negedge clk); rx_reset = 1'b1; rx_arb = arb;
    @(negedge clk); rx_reset = 1'b0; rx_arb = 1'b0;
  endtask

  // called at the first negedge after the trigger edge
  task automatic measure(string req, int len, bit sh);
    int n = 0;
    chk({req, " type while driving"}, rst_is_short, sh);
    while (drive_rst && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk({req, " drive length"}, n, len);
    chk({req, " R7 done pulse"}, done, 1);
    chk({req, " R7 done type"}, done_short, sh);
    @(negedge clk);
    chk({req, " R7 done single"}, done, 0);
  endtask

  // ends at the first negedge with the short reset driven
  task automatic start_short(string req);
    wr(4'd9, 8'h80);
    chk({req, " R3 pending readback"}, ctl_rdata[7], 1);
    @(negedge clk);
    chk({req, " R3 arb request"}, arb_req, 1);
    arb_grant = 1'b1;
    @(negedge clk);
    arb_grant = 1'b0;
    chk({req, " R3 pending cleared"}, ctl_rdata[7], 0);
  endtask

  task automatic legacy_short(string req);
    bit quiet = 1'b1;
    wr(4'd9, 8'h80);
    chk({req, " R4 bit reads 0"}, ctl_rdata[7], 0);
    repeat (6) begin
      @(negedge clk);
      if (arb_req || drive_rst) quiet = 1'b0;
    end
    chk({req, " R4 no arb no drive"}, quiet, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit quiet;
    void'($urandom(32'h5EED_0F1E));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 drive", drive_rst, 0);
    chk("R1 arb", arb_req, 0);
    chk("R1 done", done, 0);
    chk("R1 rdata", ctl_rdata, 0);
    chk("R1 type", rst_is_short, 0);

    // R2 long write
    wr(4'd9, 8'h40);
    chk("R2 no arbitration", arb_req, 0);
    measure("R2 long write", LONG_LEN, 1'b0);

    // R3 short write in short mode
    start_short("R3");
    measure("R3 short", SHORT_LEN, 1'b1);

    // R5 received resets
    rx(1'b1);
    measure("R5 rx arb short mode", SHORT_LEN, 1'b1);
    short_en_n = 1'b1;
    rx(1'b1);
    measure("R5 rx arb legacy", LONG_LEN, 1'b0);
    rx(1'b0);
    measure("R5 rx plain legacy", LONG_LEN, 1'b0);

    // R4 legacy short write ignored
    legacy_short("R4");
    short_en_n = 1'b0;

    // R6 long preempts arbitration
    wr(4'd9, 8'h80);
    @(negedge clk);
    chk("R6 arbitrating", arb_req, 1);
    rx(1'b0);
    chk("R6 arb dropped", arb_req, 0);
    measure("R6 preempt arb", LONG_LEN, 1'b0);

    // R6 long preempts a short drive
    start_short("R6");
    repeat (3) @(negedge clk);
    wr(4'd9, 8'h40);
    measure("R6 preempt drive", LONG_LEN, 1'b0);

    // R9 short write during a drive, other address
    wr(4'd9, 8'h40);
    wr(4'd9, 8'h80);
    chk("R9 write during drive ignored", ctl_rdata[7], 0);
    measure("R9 drive", LONG_LEN - 2, 1'b0);
    quiet = 1'b1;
    repeat (4) begin @(negedge clk); if (arb_req) quiet = 1'b0; end
    chk("R9 no late arbitration", quiet, 1);
    wr(4'd5, 8'hC0);
    quiet = 1'b1;
    repeat (4) begin @(negedge clk); if (arb_req || drive_rst || ctl_rdata != 0) quiet = 1'b0; end
    chk("R9 other address ignored", quiet, 1);

    // R10 strap goes high while arbitrating
    wr(4'd9, 8'h80);
    @(negedge clk);
    short_en_n = 1'b1;
    @(negedge clk);
    chk("R10 arb dropped", arb_req, 0);
    chk("R10 pending dropped", ctl_rdata[7], 0);
    short_en_n = 1'b0;
    quiet = 1'b1;
    repeat (4) begin @(negedge clk); if (arb_req || drive_rst) quiet = 1'b0; end
    chk("R10 stays dropped", quiet, 1);

    // random mix, R8 type checked inside measure
    for (int i = 0; i < 30; i++) begin
      bit smode = 1'($urandom % 2);
      int kind  = int'($urandom % 4);
      @(negedge clk);
      short_en_n = !smode;
      repeat (1 + $urandom % 4) @(negedge clk);
      case (kind)
        0: begin wr(4'd9, 8'h40); measure("R2 R8 random", exp_len(smode, kind), exp_short(smode, kind)); end
        1: begin
          if (smode) begin
            start_short("R3 random");
            measure("R8 random", exp_len(smode, kind), exp_short(smode, kind));
          end else legacy_short("R4 random");
        end
        2: begin rx(1'b0); measure("R5 R8 random", exp_len(smode, kind), exp_short(smode, kind)); end
        default: begin rx(1'b1); measure("R5 R8 random", exp_len(smode, kind), exp_short(smode, kind)); end
      endcase
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule